// File: doc/BRIEF.md
# Multi-Mode Sensor Sample FIFO

This block buffers sensor samples between a measurement data path and a read interface. Every pulse of the data-ready strobe presents one sample. Depending on a layout bit, a sample is either a three-lane X/Y/Z triple or a single magnitude word, each lane 14 bits wide. All samples share one storage array of 768 words. That array holds 256 triples, or 768 magnitude words when the layout bit is set.

A 3-bit mode code decides what happens to incoming samples. The block can be switched off, fill until full and then discard new samples, or overwrite its oldest entry once full. Two codes start in one behaviour and switch to another once a trigger input is seen. The read side always presents the oldest stored entry, and a pop advances by one entry. Level, full, empty and a sticky overrun flag report the buffer state.

Top module: `sensor_sample_fifo`

## Requirements
- R1: After reset, `level_o` is 0, `empty_o` is 1, `full_o` is 0, `overrun_o` is 0 and `rd_axes_o` is all zeros.
- R2: Mode code 000 (off) stores nothing. While it is applied, the buffer is flushed: level 0, both pointers cleared, overrun cleared.
- R3: Reserved codes 010, 101 and 111 behave exactly like code 000.
- R4: Code 001 (stop-when-full) stores samples in arrival order until the capacity is reached. A sample arriving while full is discarded, leaves the level at capacity and sets `overrun_o`.
- R5: Code 110 (ring) stores every sample. When full and not popped in the same cycle, the oldest entry is discarded, the level stays at capacity and `overrun_o` is set.
- R6: Code 011 behaves as ring until `trig_i` is sampled high, and from the following clock edge on behaves as stop-when-full. Stored contents are kept across the switch.
- R7: Code 100 behaves as off (flushed, nothing stored) until `trig_i` is sampled high, and from the following clock edge on behaves as ring.
- R8: The trigger latch is cleared whenever the mode code changes. Re-entering code 100 after any other code returns it to off.
- R9: Samples are written only on a clock edge where `drdy_i` is 1, one sample per strobe. Without the strobe the level never rises.
- R10: With `mag_sel_i`=0, capacity is 256 entries and `rd_axes_o` carries X in bits [13:0], Y in [27:14] and Z in [41:28]. With `mag_sel_i`=1, capacity is 768 entries and the magnitude is in bits [13:0] with the upper lanes zero.
- R11: A change of `mag_sel_i` flushes the buffer on that clock edge, clearing level and overrun.
- R12: `pop_i` while not empty removes the oldest entry, and `pop_i` while empty has no effect. A pop and a strobe in the same cycle leave the level unchanged when the write is accepted. `rd_axes_o` is zero while empty.
- R13: `overrun_o` stays set until a flush (R2, R3, R7 off phase, R11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Operating mode code |
| mag_sel_i | input | 1 | 0: X/Y/Z triples, 1: magnitude words |
| trig_i | input | 1 | Trigger for the two switching modes |
| drdy_i | input | 1 | Data-ready strobe, one sample per high cycle |
| axes_i | input | 42 | X [13:0], Y [27:14], Z [41:28] |
| mag_data_i | input | 14 | Magnitude sample |
| pop_i | input | 1 | Remove the oldest entry |
| rd_axes_o | output | 42 | Oldest entry, zero when empty |
| level_o | output | 10 | Number of stored entries |
| full_o | output | 1 | Level equals current capacity |
| empty_o | output | 1 | Level is zero |
| overrun_o | output | 1 | Sticky loss indication |

## Verification
A wrong pointer or count shows at the read port on the very next pop, because the scoreboard compares every popped entry against the expected arrival order. A wrong layout or wrap shows when a buffer is drained across the 768-word boundary. A trigger latch in the wrong state shows one sample after the trigger. The level either keeps rising past capacity, or full samples get dropped where they should overwrite, and the next level and overrun comparison exposes it. A missed flush leaves a non-zero level, or a set overrun flag, visible one clock after the mode or layout change.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef enum logic [1:0] {
        BEH_OFF  = 2'd0,
        BEH_STOP = 2'd1,
        BEH_RING = 2'd2
    } beh_e;

    localparam logic [2:0] MODE_OFF         = 3'b000;
    localparam logic [2:0] MODE_STOP        = 3'b001;
    localparam logic [2:0] MODE_RING_TO_STOP = 3'b011;
    localparam logic [2:0] MODE_OFF_TO_RING = 3'b100;
    localparam logic [2:0] MODE_RING        = 3'b110;

    function automatic logic is_trig_mode(input logic [2:0] code);
        return (code == MODE_RING_TO_STOP) || (code == MODE_OFF_TO_RING);
    endfunction

    // Reserved codes fall through to BEH_OFF.
    function automatic beh_e decode_mode(input logic [2:0] code, input logic armed);
        beh_e b;
        case (code)
            MODE_STOP:         b = BEH_STOP;
            MODE_RING:         b = BEH_RING;
            MODE_RING_TO_STOP: b = armed ? BEH_STOP : BEH_RING;
            MODE_OFF_TO_RING:  b = armed ? BEH_RING : BEH_OFF;
            default:           b = BEH_OFF;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sfifo_mode_ctl.sv
module sfifo_mode_ctl
    import sfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       trig_i,
    output beh_e       beh_o
);

    typedef struct packed {
        logic [2:0] mode;
        logic       armed;
    } mode_st_t;

    mode_st_t st_d, st_q;
    logic     same_mode;
    logic     armed_now;

    always_comb begin
        same_mode     = (mode_i == st_q.mode);
        // a latch armed under another code never counts for the new one
        armed_now     = st_q.armed && same_mode;
        st_d.mode     = mode_i;
        st_d.armed    = is_trig_mode(mode_i) && same_mode && (st_q.armed || trig_i);
        beh_o         = decode_mode(mode_i, armed_now);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sfifo_ptr_ctl.sv
module sfifo_ptr_ctl
    import sfifo_pkg::*;
#(
    parameter int WORDS = 768,
    parameter int AXES  = 3,
    parameter int PTR_W = $clog2(WORDS),
    parameter int CNT_W = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  beh_e             beh_i,
    input  logic             mag_sel_i,
    input  logic             drdy_i,
    input  logic             pop_i,
    output logic             we_o,
    output logic             lay_mag_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [CNT_W-1:0] level_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             overrun_o
);

    localparam int SAMPLES = WORDS / AXES;

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             ovr;
        logic             mag;
    } ptr_st_t;

    ptr_st_t    st_d, st_q;
    int         step;
    logic [CNT_W-1:0] cap;
    logic       full, empty, flush, pop_ok, store, evict, lost;

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p, input int s);
        int sum;
        sum = int'(p) + s;
        if (sum >= WORDS) begin
            sum = sum - WORDS;
        end
        return PTR_W'(sum);
    endfunction

    always_comb begin
        step   = st_q.mag ? 1 : AXES;
        cap    = st_q.mag ? CNT_W'(WORDS) : CNT_W'(SAMPLES);
        full   = (st_q.count == cap);
        empty  = (st_q.count == '0);
        flush  = (beh_i == BEH_OFF) || (mag_sel_i != st_q.mag);
        pop_ok = pop_i && !empty && !flush;
        store  = drdy_i && !flush && ((beh_i == BEH_RING) || !full);
        evict  = drdy_i && !flush && (beh_i == BEH_RING) && full && !pop_ok;
        lost   = drdy_i && !flush && (beh_i == BEH_STOP) && full;

        st_d     = st_q;
        st_d.mag = mag_sel_i;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
            st_d.ovr    = 1'b0;
        end else begin
            if (store) begin
                st_d.wr_ptr = advance(st_q.wr_ptr, step);
            end
            if (pop_ok || evict) begin
                st_d.rd_ptr = advance(st_q.rd_ptr, step);
            end
            st_d.count = st_q.count + CNT_W'(store) - CNT_W'(pop_ok) - CNT_W'(evict);
            st_d.ovr   = st_q.ovr | evict | lost;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign we_o      = store;
    assign lay_mag_o = st_q.mag;
    assign wr_ptr_o  = st_q.wr_ptr;
    assign rd_ptr_o  = st_q.rd_ptr;
    assign level_o   = st_q.count;
    assign full_o    = full;
    assign empty_o   = empty;
    assign overrun_o = st_q.ovr;

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DATA_W = 14,
    parameter int AXES   = 3,
    parameter int WORDS  = 768,
    parameter int PTR_W  = $clog2(WORDS)
) (
    input  logic                   clk,
    input  logic                   we_i,
    input  logic                   mag_i,
    input  logic [PTR_W-1:0]       wr_ptr_i,
    input  logic [AXES*DATA_W-1:0] axes_i,
    input  logic [DATA_W-1:0]      mag_data_i,
    input  logic [PTR_W-1:0]       rd_ptr_i,
    output logic [AXES*DATA_W-1:0] rd_o
);

    logic [DATA_W-1:0] mem [WORDS];

    // Triples occupy consecutive words X, Y, Z; WORDS is a multiple of AXES,
    // so an aligned pointer never needs a wrap inside one triple.
    always_ff @(posedge clk) begin
        if (we_i) begin
            for (int a = 0; a < AXES; a++) begin
                if (a == 0 || !mag_i) begin
                    mem[wr_ptr_i + PTR_W'(a)] <= mag_i ? mag_data_i : axes_i[a*DATA_W +: DATA_W];
                end
            end
        end
    end

    for (genvar g = 0; g < AXES; g++) begin : g_lane
        logic [PTR_W:0] addr;
        logic           lane_on;
        assign addr    = {1'b0, rd_ptr_i} + (PTR_W+1)'(g);
        assign lane_on = ((g == 0) || !mag_i) && (addr < (PTR_W+1)'(WORDS));
        assign rd_o[g*DATA_W +: DATA_W] = lane_on ? mem[addr[PTR_W-1:0]] : '0;
    end

endmodule

// File: rtl/sensor_sample_fifo.sv
module sensor_sample_fifo
    import sfifo_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int AXES    = 3,
    parameter int SAMPLES = 256,
    localparam int WORDS  = SAMPLES * AXES,
    localparam int PTR_W  = $clog2(WORDS),
    localparam int CNT_W  = $clog2(WORDS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             mode_i,
    input  logic                   mag_sel_i,
    input  logic                   trig_i,
    input  logic                   drdy_i,
    input  logic [AXES*DATA_W-1:0] axes_i,
    input  logic [DATA_W-1:0]      mag_data_i,
    input  logic                   pop_i,
    output logic [AXES*DATA_W-1:0] rd_axes_o,
    output logic [CNT_W-1:0]       level_o,
    output logic                   full_o,
    output logic                   empty_o,
    output logic                   overrun_o
);

    beh_e                   beh;
    logic                   we;
    logic                   lay_mag;
    logic [PTR_W-1:0]       wr_ptr, rd_ptr;
    logic [AXES*DATA_W-1:0] lanes;

    sfifo_mode_ctl u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .trig_i (trig_i),
        .beh_o  (beh)
    );

    sfifo_ptr_ctl #(
        .WORDS (WORDS),
        .AXES  (AXES),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .beh_i     (beh),
        .mag_sel_i (mag_sel_i),
        .drdy_i    (drdy_i),
        .pop_i     (pop_i),
        .we_o      (we),
        .lay_mag_o (lay_mag),
        .wr_ptr_o  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .level_o   (level_o),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .overrun_o (overrun_o)
    );

    sfifo_store #(
        .DATA_W (DATA_W),
        .AXES   (AXES),
        .WORDS  (WORDS),
        .PTR_W  (PTR_W)
    ) u_store (
        .clk        (clk),
        .we_i       (we),
        .mag_i      (lay_mag),
        .wr_ptr_i   (wr_ptr),
        .axes_i     (axes_i),
        .mag_data_i (mag_data_i),
        .rd_ptr_i   (rd_ptr),
        .rd_o       (lanes)
    );

    assign rd_axes_o = empty_o ? '0 : lanes;

endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
    parameter int SAMPLES = 256,
    parameter int WORDS   = 768,
    parameter int CNT_W   = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_i,
    input logic             mag_sel_i,
    input logic             drdy_i,
    input logic             pop_i,
    input logic [CNT_W-1:0] level_o,
    input logic             full_o,
    input logic             empty_o,
    input logic             overrun_o
);

    p_off_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b000) |=> (level_o == '0) && !overrun_o);

    p_reserved_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b010 || mode_i == 3'b101 || mode_i == 3'b111) |=> (level_o == '0) && !overrun_o);

    p_stop_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b001 && $stable(mode_i) && $stable(mag_sel_i) && $past(rst_n)
         && full_o && drdy_i && !pop_i)
        |=> full_o && overrun_o && $stable(level_o));

    p_ring_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b110 && $stable(mag_sel_i) && $past(rst_n) && full_o && drdy_i && !pop_i)
        |=> full_o && overrun_o);

    p_rearm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b100 && !$stable(mode_i) && $past(rst_n)) |=> (level_o == '0));

    p_strobe_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy_i |=> (level_o <= $past(level_o)));

    p_full_at_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (level_o == CNT_W'(SAMPLES)) || (level_o == CNT_W'(WORDS)));

    p_layout_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mag_sel_i) && $past(rst_n)) |=> (level_o == '0) && !overrun_o);

    p_empty_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !drdy_i) |=> empty_o);

    p_overrun_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && $stable(mag_sel_i) && $past(rst_n)
         && (mode_i == 3'b001 || mode_i == 3'b110 || mode_i == 3'b011))
        |=> overrun_o);

endmodule

bind sensor_sample_fifo sfifo_chk #(
    .SAMPLES (SAMPLES),
    .WORDS   (WORDS),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .mag_sel_i (mag_sel_i),
    .drdy_i    (drdy_i),
    .pop_i     (pop_i),
    .level_o   (level_o),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .overrun_o (overrun_o)
);

// File: tb/sensor_sample_fifo_tb.sv
module sensor_sample_fifo_tb;

    localparam int DATA_W  = 14;
    localparam int AXES    = 3;
    localparam int SAMPLES = 256;
    localparam int WORDS   = SAMPLES * AXES;
    localparam int CNT_W   = $clog2(WORDS + 1);
    localparam int LW      = AXES * DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        mode_i = 3'b000;
    logic              mag_sel_i = 1'b0;
    logic              trig_i = 1'b0;
    logic              drdy_i = 1'b0;
    logic [LW-1:0]     axes_i = '0;
    logic [DATA_W-1:0] mag_data_i = '0;
    logic              pop_i = 1'b0;
    logic [LW-1:0]     rd_axes_o;
    logic [CNT_W-1:0]  level_o;
    logic              full_o, empty_o, overrun_o;

    sensor_sample_fifo #(
        .DATA_W  (DATA_W),
        .AXES    (AXES),
        .SAMPLES (SAMPLES)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .mag_sel_i  (mag_sel_i),
        .trig_i     (trig_i),
        .drdy_i     (drdy_i),
        .axes_i     (axes_i),
        .mag_data_i (mag_data_i),
        .pop_i      (pop_i),
        .rd_axes_o  (rd_axes_o),
        .level_o    (level_o),
        .full_o     (full_o),
        .empty_o    (empty_o),
        .overrun_o  (overrun_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // expected-contents queue and mode model
    logic [LW-1:0] exp_q[$];
    int m_mode = 0;
    bit m_armed = 1'b0;
    bit m_mag = 1'b0;
    bit m_ovr = 1'b0;
    int seq = 1;

    function automatic int beh();   // 0 off, 1 stop, 2 ring
        case (m_mode)
            1: return 1;
            6: return 2;
            3: return m_armed ? 1 : 2;
            4: return m_armed ? 2 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int cap();
        return m_mag ? WORDS : SAMPLES;
    endfunction

    function automatic void flush_model();
        exp_q.delete();
        m_ovr = 1'b0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        logic [LW-1:0] front;
        front = (exp_q.size() != 0) ? exp_q[0] : '0;
        check(level_o == CNT_W'(exp_q.size()), {tag, " level"}, 64'(level_o), 64'(exp_q.size()));
        check(full_o == (exp_q.size() == cap()), {tag, " full"}, 64'(full_o), 64'(exp_q.size() == cap()));
        check(empty_o == (exp_q.size() == 0), {tag, " empty"}, 64'(empty_o), 64'(exp_q.size() == 0));
        check(overrun_o == m_ovr, {tag, " overrun"}, 64'(overrun_o), 64'(m_ovr));
        check(rd_axes_o == front, {tag, " head"}, 64'(rd_axes_o), 64'(front));
    endtask

    // driver: one strobe, expected entry pushed into the scoreboard per mode
    task automatic drive_sample(input bit with_pop);
        logic [DATA_W-1:0] x, y, z, mg;
        logic [LW-1:0] item;
        bit was_full, popped;
        x  = DATA_W'(seq);
        y  = DATA_W'(seq * 7 + 100);
        z  = DATA_W'(seq * 13 + 5);
        mg = DATA_W'(seq * 3 + 1);
        seq++;
        axes_i     = {z, y, x};
        mag_data_i = mg;
        drdy_i     = 1'b1;
        pop_i      = with_pop;
        item = m_mag ? {{(LW-DATA_W){1'b0}}, mg} : {z, y, x};
        @(posedge clk);
        was_full = (exp_q.size() == cap());
        popped   = 1'b0;
        if (beh() != 0 && with_pop && exp_q.size() != 0) begin
            void'(exp_q.pop_front());
            popped = 1'b1;
        end
        if (beh() == 1) begin
            if (was_full) m_ovr = 1'b1;
            else exp_q.push_back(item);
        end else if (beh() == 2) begin
            if (was_full && !popped) begin
                void'(exp_q.pop_front());
                m_ovr = 1'b1;
            end
            exp_q.push_back(item);
        end
        @(negedge clk);
        drdy_i = 1'b0;
        pop_i  = 1'b0;
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) drive_sample(1'b0);
    endtask

    // monitor: compare the head with the scoreboard, then pop it
    task automatic pop_cmp(input string tag);
        logic [LW-1:0] exp;
        exp = (exp_q.size() != 0) ? exp_q[0] : '0;
        check(rd_axes_o == exp, tag, 64'(rd_axes_o), 64'(exp));
        pop_i = 1'b1;
        @(posedge clk);
        if (exp_q.size() != 0 && beh() != 0) void'(exp_q.pop_front());
        @(negedge clk);
        pop_i = 1'b0;
    endtask

    task automatic drain(input string tag);
        while (exp_q.size() != 0) pop_cmp(tag);
        check_state({tag, " drained"});
    endtask

    task automatic set_mode(input int code);
        mode_i = 3'(code);
        if (code != m_mode) m_armed = 1'b0;
        m_mode = code;
        @(posedge clk);
        if (beh() == 0) flush_model();
        @(negedge clk);
    endtask

    task automatic fire_trigger();
        trig_i = 1'b1;
        @(posedge clk);
        if (beh() == 0) flush_model();
        if (m_mode == 3 || m_mode == 4) m_armed = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
    endtask

    task automatic set_mag(input bit v);
        mag_sel_i = v;
        @(posedge clk);
        flush_model();
        m_mag = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_state("R1 reset");

        // R2 / R9: off mode stores nothing
        send(3);
        check_state("R2 off R9");
        pop_cmp("R12 pop empty");
        check_state("R12 empty after pop");

        // R4 stop-when-full with triples (R10 layout)
        set_mode(1);
        send(5);
        check_state("R4 partial R10");
        pop_cmp("R4 order");
        pop_cmp("R4 order");
        drive_sample(1'b1);
        check_state("R12 pop+write");
        send(SAMPLES - exp_q.size() + 2);
        check_state("R4 full drop");
        pop_cmp("R13 pop keeps overrun");
        check_state("R13 sticky");
        fire_trigger();
        check_state("R6 trigger ignored in stop");
        drain("R4");
        set_mode(0);
        check_state("R2 flush");

        // R3 reserved codes
        set_mode(2); send(2); check_state("R3 code 010");
        set_mode(5); send(2); check_state("R3 code 101");
        set_mode(7); send(2); check_state("R3 code 111");

        // R5 ring with triples
        set_mode(6);
        send(SAMPLES + 4);
        check_state("R5 overwrite");
        drain("R5");

        // R10 / R11 magnitude layout
        send(7);
        set_mag(1'b1);
        check_state("R11 layout flush");
        send(WORDS + 3);
        check_state("R10 mag full R5");
        drain("R10 mag");
        send(5);
        set_mag(1'b0);
        check_state("R11 back to triples");

        // R6 ring then stop
        set_mode(3);
        send(SAMPLES + 1);
        check_state("R6 ring phase");
        set_mode(0);
        set_mode(3);
        send(5);
        fire_trigger();
        send(SAMPLES - 5 + 2);
        check_state("R6 stop phase");
        drain("R6");

        // R7 off until trigger, then ring
        set_mode(4);
        send(2);
        check_state("R7 before trigger");
        fire_trigger();
        send(3);
        check_state("R7 after trigger");
        send(SAMPLES);
        check_state("R7 ring overflow");

        // R8 latch cleared by a mode change
        set_mode(1);
        check_state("R8 kept under 001");
        set_mode(4);
        send(2);
        check_state("R8 re-entry off");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule